// File: doc/BRIEF.md
# Convolutional Encoder with Run-Time Symbol Packer

This block protects a serial data stream with a rate one-half, constraint length seven convolutional code and groups the coded stream into transmit symbols whose width is chosen at run time, from one to five bits. Each accepted data bit enters a seven-tap window. Two parity bits are formed from that window and placed into one serial coded stream, the first-polynomial bit always ahead of the second. That stream is cut into symbols with the earliest bit at the top. Symbol edges do not follow pair edges, so a coded pair can be split across two symbols.

Data enters through a valid/ready port, one bit per transfer. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid` and `in_bit` until that edge. Symbols leave through a valid/ready port. Once `out_valid` is high, it and `out_sym` stay unchanged until an edge with `out_ready` high. Back-pressure from `out_ready` stalls the serializer, and that in turn drops `in_ready`.

A one-cycle `flush` pulse drives six zero bits through the coder, which returns it to the all-zero state. Any partial symbol that remains is then padded with zeros and sent. `sym_width` is a plain control input. It may change only while the block is idle: no input in flight and no partial symbol held.

Top module: `cfec_sym_encoder`

## Requirements
- R1: With the window taps numbered T1 (newest accepted bit) to T7 (oldest), the first coded bit of each pair is T1^T3^T4^T6^T7, where the window is taken after the new bit has entered it.
- R2: The second coded bit of each pair is T1^T2^T3^T4^T7, taken from the same window as R1.
- R3: Coded bits are serialized with the R1 bit first. They are packed MSB-first into the low n bits of `out_sym`: the earliest bit sits at bit n-1, and bits n and above read zero.
- R4: The symbol width n follows `sym_width` for values 1 to 5. A value of 0 acts as 1, and values above 5 act as 5.
- R5: A symbol is emitted as soon as it holds n bits, whatever the pair boundaries. With odd n, a pair straddles two symbols.
- R6: An input transfer happens only when `in_valid` and `in_ready` are both high. After a transfer, `in_ready` is low in the following cycle, so at most one bit is taken every two cycles.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sym` holds its value.
- R8: A `flush` pulse seen while `in_ready` is high pulls `in_ready` low from the next cycle. It then encodes six zero bits, leaving the coder in the all-zero state. `in_ready` returns high only once the flush has ended.
- R9: After the flush bits, a partial symbol of k bits (0<k<n) is sent with its bits at the top of the n-bit field and zeros below. If no bits remain, no extra symbol is sent.
- R10: Reset clears the coder window and the packing count. `out_valid` is low and `in_ready` is high after reset.
- R11: With the packer empty, n=2 and `out_ready` high, a symbol becomes valid exactly two clock edges after the edge that accepted its data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_width | input | 3 | Symbol width select, clamped to 1..5 |
| flush | input | 1 | Single-cycle request to flush the coder and pad the last symbol |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Block can take a data bit this cycle |
| in_bit | input | 1 | Data bit |
| out_valid | output | 1 | Symbol available |
| out_ready | input | 1 | Sink takes the symbol this cycle |
| out_sym | output | 5 | Symbol, first coded bit at position n-1 |

## Verification
An accepted bit produces its first coded bit in the packer one edge later and its second one edge after that. A symbol is therefore due two edges after the data bit that completes it, and the bench checks this exact count once, in a directed run with n=2. The bench drives inputs and samples outputs just after the falling edge. It records each transfer as the pending handshake for the next rising edge, so a reference coder and packer in the bench, running on those records, predict every symbol in order. Flush completion is only timed loosely: the bench checks that `in_ready` is low one edge after the flush request, then waits for `in_ready` and the expected symbol queue to settle before the next phase.

// File: rtl/cfec_pkg.sv
package cfec_pkg;
  // Window length of the code (constraint length).
  localparam int K_LEN = 7;
  // Tap masks: bit i is window tap T(i+1), bit 0 the newest bit.
  localparam logic [K_LEN-1:0] POLY_A = 7'b1101101; // T1 T3 T4 T6 T7
  localparam logic [K_LEN-1:0] POLY_B = 7'b1001111; // T1 T2 T3 T4 T7
  // Zero bits driven in by a flush.
  localparam int FLUSH_BITS = K_LEN - 1;
endpackage

// File: rtl/cfec_coder.sv
module cfec_coder
  import cfec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,      // take din into the window this cycle
  input  logic din,
  input  logic take,      // packer consumes ser_bit this cycle
  output logic ser_valid,
  output logic ser_bit,
  output logic free       // a load may happen this cycle
);
  localparam int HW = K_LEN - 1;
  localparam logic [1:0][K_LEN-1:0] POLYS = {POLY_A, POLY_B};

  logic [HW-1:0]    hist;   // hist[i] is tap T(i+2) for the next bit
  logic [K_LEN-1:0] taps;
  logic [1:0]       coded;  // coded[1] is sent first
  logic [1:0]       pair;
  logic [1:0]       pend;

  assign taps = {hist, din};

  for (genvar j = 0; j < 2; j++) begin : g_poly
    assign coded[j] = ^(taps & POLYS[j]);
  end

  assign ser_valid = (pend != 2'd0);
  assign ser_bit   = pair[1];
  assign free      = (pend == 2'd0) || (pend == 2'd1 && take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      pair <= '0;
      pend <= '0;
    end else if (load) begin
      hist <= {hist[HW-2:0], din};
      pair <= coded;
      pend <= 2'd2;
    end else if (take) begin
      pair <= {pair[0], 1'b0};
      pend <= pend - 2'd1;
    end
  end
endmodule

// File: rtl/cfec_flushctl.sv
module cfec_flushctl
  import cfec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic in_valid,
  input  logic in_bit,
  input  logic free,
  input  logic ser_valid,
  input  logic pad_ack,
  output logic in_ready,
  output logic load,
  output logic load_bit,
  output logic pad_req
);
  localparam int FW = $clog2(FLUSH_BITS + 1);

  logic          busy;
  logic [FW-1:0] left;

  assign in_ready = free && !busy;
  assign load     = busy ? (left != '0 && free) : (in_valid && in_ready);
  assign load_bit = busy ? 1'b0 : in_bit;
  assign pad_req  = busy && (left == '0) && !ser_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy) begin
      if (flush) begin
        busy <= 1'b1;
        left <= FW'(FLUSH_BITS);
      end
    end else begin
      if (load) left <= left - 1'b1;
      if (pad_ack) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfec_packer.sv
module cfec_packer #(
  parameter int MAX_SYM_W = 5,
  localparam int WW = $clog2(MAX_SYM_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WW-1:0]        width_sel,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic                 pad_req,
  input  logic                 out_ready,
  output logic                 take,
  output logic                 pad_ack,
  output logic                 out_valid,
  output logic [MAX_SYM_W-1:0] out_sym
);
  logic [WW-1:0]        w;
  logic [WW-1:0]        cnt;
  logic [MAX_SYM_W-1:0] acc;
  logic [MAX_SYM_W-1:0] acc_n;
  logic                 slot_free;

  always_comb begin
    if (width_sel == '0)                  w = WW'(1);
    else if (width_sel > WW'(MAX_SYM_W))  w = WW'(MAX_SYM_W);
    else                                  w = width_sel;
  end

  assign slot_free = !out_valid || out_ready;
  assign take      = bit_valid && slot_free;
  assign pad_ack   = pad_req && slot_free;
  assign acc_n     = {acc[MAX_SYM_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (cnt == w - 1'b1) begin
          out_sym   <= acc_n;
          out_valid <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_n;
          cnt <= cnt + 1'b1;
        end
      end else if (pad_ack && cnt != '0) begin
        out_sym   <= acc << (w - cnt);
        out_valid <= 1'b1;
        acc       <= '0;
        cnt       <= '0;
      end
    end
  end
endmodule

// File: rtl/cfec_sym_encoder.sv
module cfec_sym_encoder #(
  parameter int MAX_SYM_W = 5,
  localparam int WW = $clog2(MAX_SYM_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WW-1:0]        sym_width,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_bit,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [MAX_SYM_W-1:0] out_sym
);
  logic load, load_bit, free, ser_valid, ser_bit, take, pad_req, pad_ack;

  cfec_coder u_coder (
    .clk(clk), .rst_n(rst_n), .load(load), .din(load_bit), .take(take),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .free(free)
  );

  cfec_flushctl u_flush (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_bit(in_bit), .free(free), .ser_valid(ser_valid), .pad_ack(pad_ack),
    .in_ready(in_ready), .load(load), .load_bit(load_bit), .pad_req(pad_req)
  );

  cfec_packer #(.MAX_SYM_W(MAX_SYM_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .width_sel(sym_width), .bit_valid(ser_valid),
    .bit_in(ser_bit), .pad_req(pad_req), .out_ready(out_ready), .take(take),
    .pad_ack(pad_ack), .out_valid(out_valid), .out_sym(out_sym)
  );
endmodule

// File: rtl/cfec_sym_encoder_chk.sv
module cfec_sym_encoder_chk #(
  parameter int MAX_SYM_W = 5,
  localparam int WW = $clog2(MAX_SYM_W + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WW-1:0]        sym_width,
  input logic                 flush,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [MAX_SYM_W-1:0] out_sym
);
  logic [WW-1:0] eff_w;
  always_comb begin
    eff_w = sym_width;
    if (sym_width == '0) eff_w = WW'(1);
    if (sym_width > WW'(MAX_SYM_W)) eff_w = WW'(MAX_SYM_W);
  end

  // R7
  hold_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sym));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sym >> eff_w) == '0);

  // R6
  one_per_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && in_ready |=> !in_ready);
endmodule

bind cfec_sym_encoder cfec_sym_encoder_chk #(.MAX_SYM_W(MAX_SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_width(sym_width), .flush(flush),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sym(out_sym)
);

// File: tb/sim_cfec_sym_encoder.sv
module sim_cfec_sym_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 150000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] sym_width = 3'd2;
  logic       flush = 0;
  logic       in_valid = 0;
  logic       in_bit = 0;
  logic       out_ready = 0;
  logic       in_ready, out_valid;
  logic [4:0] out_sym;

  cfec_sym_encoder u0 (
    .clk(clk), .rst_n(rst_n), .sym_width(sym_width), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit timed_out = 0;
  string tag = "R10";
  int exp_q[$];

  // reference model
  logic [5:0] m_h = '0;
  int m_acc = 0, m_cnt = 0, m_w = 2;

  function automatic int clampw(int v);
    if (v == 0) return 1;
    if (v > 5) return 5;
    return v;
  endfunction

  function automatic void m_push(bit b);
    m_acc = (m_acc << 1) | int'(b);
    m_cnt++;
    if (m_cnt == m_w) begin exp_q.push_back(m_acc); m_acc = 0; m_cnt = 0; end
  endfunction

  function automatic void m_enc(bit b);
    bit pa, pb;
    pa = b ^ m_h[1] ^ m_h[2] ^ m_h[4] ^ m_h[5];  // T1 T3 T4 T6 T7
    pb = b ^ m_h[0] ^ m_h[1] ^ m_h[2] ^ m_h[5];  // T1 T2 T3 T4 T7
    m_h = {m_h[4:0], b};
    m_push(pa);
    m_push(pb);
  endfunction

  function automatic void m_flush();
    for (int i = 0; i < 6; i++) m_enc(1'b0);
    if (m_cnt != 0) exp_q.push_back(m_acc << (m_w - m_cnt));
    m_acc = 0; m_cnt = 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit gen_in = 0, fired_in = 0, man_valid = 0, man_bit = 0, man_flush = 0;
  int left = 0, rdy_pct = 75;

  task automatic step();
    @(negedge clk);
    if (gen_in) begin
      if (!in_valid || fired_in) begin
        if (left > 0 && $urandom_range(3) != 0) begin
          in_valid = 1; in_bit = 1'($urandom_range(1));
        end else in_valid = 0;
      end
    end else begin
      in_valid = man_valid; in_bit = man_bit;
    end
    flush = man_flush;
    out_ready = ($urandom_range(99) < rdy_pct);
    #1;
    fired_in = in_valid && in_ready;
    if (fired_in) begin m_enc(in_bit); if (gen_in) left--; end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check({tag, " unexpected symbol"}, int'(out_sym), -1);
      else check({tag, " symbol"}, int'(out_sym), exp_q.pop_front());
    end
    cycles++;
    if (cycles > MAXC) timed_out = 1;
  endtask

  task automatic drain();
    while (!timed_out && !(exp_q.size() == 0 && in_ready && !out_valid)) step();
  endtask

  task automatic do_flush();
    man_valid = 0; man_flush = 1;
    step();
    m_flush();
    man_flush = 0;
    step();
    check("R8 in_ready low after flush", int'(in_ready), 0);
    drain();
  endtask

  task automatic run_phase(int w, int n, string t);
    sym_width = 3'(w); m_w = clampw(w); tag = t;
    left = n; gen_in = 1;
    while (left > 0 && !timed_out) step();
    gen_in = 0;
    do_flush();
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 in_ready after reset", int'(in_ready), 1);

    // R11 / R1 / R2 / R6: first bit 1 from zero state, n=2 -> symbol 2'b11
    sym_width = 3'd2; m_w = 2; tag = "R11"; rdy_pct = 100;
    man_valid = 1; man_bit = 1;
    step();
    man_valid = 0;
    step();
    check("R11 not valid after 1 edge", int'(out_valid), 0);
    check("R6 in_ready low after transfer", int'(in_ready), 0);
    step();
    check("R11 not valid after 1 edge+", int'(out_valid), 0);
    step();
    check("R11 valid after 2 edges", int'(out_valid), 1);
    check("R1 R2 first pair", int'(out_sym), 3);
    do_flush();

    // R7 stall: n=1, sink blocked
    sym_width = 3'd1; m_w = 1; tag = "R7"; rdy_pct = 0;
    man_valid = 1; man_bit = 1;
    step();
    man_valid = 0;
    repeat (3) step();
    check("R7 valid held", int'(out_valid), 1);
    check("R7 symbol held", int'(out_sym), 1);
    repeat (4) step();
    check("R7 valid still held", int'(out_valid), 1);
    check("R7 symbol still held", int'(out_sym), 1);
    rdy_pct = 100;
    do_flush();

    // R9 pad: n=4, three bits -> 18 coded bits, 2 left -> padded
    sym_width = 3'd4; m_w = 4; tag = "R9"; rdy_pct = 100;
    for (int i = 0; i < 3; i++) begin
      man_valid = 1; man_bit = 1'(i != 1);
      step();
      while (!fired_in && !timed_out) step();
    end
    man_valid = 0;
    do_flush();

    // random phases over all widths, plus clamped values
    rdy_pct = 75;
    run_phase(1, 60, "R1 R3 w1");
    run_phase(2, 80, "R2 R3 w2");
    run_phase(3, 80, "R5 w3");
    run_phase(4, 80, "R3 w4");
    run_phase(5, 80, "R5 w5");
    run_phase(0, 40, "R4 w0");
    run_phase(7, 40, "R4 w7");
    run_phase(6, 40, "R4 w6");

    check("R3 all symbols seen", exp_q.size(), 0);
    if (timed_out) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, MAXC);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule